// File: doc/BRIEF.md
# Serial byte transmitter with end-of-transmission interrupt

This block turns bytes written by a host into asynchronous serial frames on a single output line. The host writes a byte into a holding register, then hands it to the transmitter by clearing a "holding register empty" flag. The transmitter copies the byte into its shift register at the next frame boundary and sets the empty flag again, so the host can queue the following byte while the current one is still on the line. When the stop bit of a frame finishes and no byte is waiting, a "transmission done" flag is raised. If the done interrupt is enabled, that flag drives an interrupt output.

Both flags are cleared by a two-step handshake. The host reads the status register while the flag is 1, and then writes 0 to that flag position. A write of 0 that was not preceded by such a read is discarded. Bit timing comes from an external single-cycle baud tick; each bit lasts a fixed number of ticks. The register port is a plain read/write strobe interface with a combinational read data path. It has no valid/ready stream, and nothing stalls the host: back-pressure is expressed only through the empty flag.

Top module: `uart_txe`

## Requirements
- R1: After reset the line output is 1, the empty flag (status bit 0) and the done flag (status bit 1) both read 1, the interrupt enable (control bit 0) reads 0 and the interrupt output is 0.
- R2: A frame is a 0 start bit, then DATA_W data bits with the least significant bit first, then a 1 stop bit. Each bit lasts TICKS_PER_BIT baud ticks.
- R3: Register map: address 0 is the holding register (read back as written), address 1 is status, and address 2 is control. Status and control bits not named here read 0.
- R4: A write of 0 to a status flag clears it only if status was read with that flag at 1 since the flag was last set or cleared. Otherwise that write is ignored. Writing 1 to a flag never changes it.
- R5: Clearing the empty flag marks the byte as present. An idle transmitter loads it on the next clock edge and starts the start bit, and the load sets the empty flag back to 1.
- R6: When the stop bit ends with no byte present, the done flag is set and the line stays at 1.
- R7: When a byte is present as the stop bit ends, the next start bit follows with no idle gap and the done flag stays 0.
- R8: The interrupt output is the done flag gated by the enable. Clearing the enable removes a pending interrupt.
- R9: A pending interrupt is withdrawn by reading status with the empty flag at 1 and then writing 0 to both flags.
- R10: The done flag is cleared whenever a frame starts.
- R11: Writing the holding register changes neither the flags nor the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse that advances bit timing |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; this strobe arms the flags for clearing |
| reg_addr | input | 2 | Register address (0 data, 1 status, 2 control) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the addressed register |
| txd | output | 1 | Serial line, 1 when idle |
| tx_end_irq | output | 1 | Transmission-done interrupt request |

## Verification
The bench builds the block with DATA_W = 8 and TICKS_PER_BIT = 2, and supplies a baud tick every third clock. A full frame therefore takes about sixty cycles. This makes it practical to run several byte patterns, a back-to-back pair and the flag handshake corner cases in one short run. The short bit period also lets a second byte be queued well inside the first frame, which exercises the gap-free restart at the stop-bit boundary.

// File: rtl/txe_pkg.sv
package txe_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2
  } txe_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } txe_state_e;

  localparam int STAT_EMPTY_BIT = 0;
  localparam int STAT_DONE_BIT  = 1;
  localparam int CTRL_IE_BIT    = 0;

endpackage

// File: rtl/txe_regfile.sv
module txe_regfile
  import txe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              take,
  input  logic              done_idle,
  output logic              data_avail,
  output logic [DATA_W-1:0] hold_q,
  output logic              done_q,
  output logic              ie_q
);

  logic empty_q;
  logic arm_empty, arm_done;
  logic rd_stat, wr_stat, wr_data, wr_ctrl;
  logic clr_empty, clr_done;

  assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  // A zero written to a flag counts only after that flag was seen at 1.
  assign clr_empty = wr_stat && !reg_wdata[STAT_EMPTY_BIT] && arm_empty;
  assign clr_done  = wr_stat && !reg_wdata[STAT_DONE_BIT]  && arm_done;

  assign data_avail = !empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_data) hold_q <= reg_wdata;
      if (wr_ctrl) ie_q   <= reg_wdata[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q   <= 1'b1;
      arm_empty <= 1'b0;
    end else begin
      if (take)           empty_q <= 1'b1;
      else if (clr_empty) empty_q <= 1'b0;

      if (take || clr_empty)       arm_empty <= 1'b0;
      else if (rd_stat && empty_q) arm_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b1;
      arm_done <= 1'b0;
    end else begin
      if (take)           done_q <= 1'b0;
      else if (done_idle) done_q <= 1'b1;
      else if (clr_done)  done_q <= 1'b0;

      if (take || done_idle || clr_done) arm_done <= 1'b0;
      else if (rd_stat && done_q)        arm_done <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_DATA: reg_rdata = hold_q;
      ADDR_STAT: begin
        reg_rdata[STAT_EMPTY_BIT] = empty_q;
        reg_rdata[STAT_DONE_BIT]  = done_q;
      end
      ADDR_CTRL: reg_rdata[CTRL_IE_BIT] = ie_q;
      default:   reg_rdata = '0;
    endcase
  end

  p_take_sets_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> empty_q);

  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_idle |=> done_q);

  p_empty_fall_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_q) |-> $past(wr_stat) && $past(arm_empty));

  p_data_write_keeps_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !take && !done_idle) |=> $stable(empty_q) && $stable(done_q));

endmodule

// File: rtl/txe_engine.sv
module txe_engine
  import txe_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              data_avail,
  input  logic [DATA_W-1:0] data_in,
  output logic              take,
  output logic              done_idle,
  output logic              busy,
  output logic              txd
);

  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  txe_state_e        state_q;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  tick_cnt_q;
  logic [IDX_W-1:0]  bit_idx_q;
  logic              bit_end;

  assign bit_end   = baud_tick && (tick_cnt_q == CNT_LAST);
  assign take      = data_avail && ((state_q == ST_IDLE) ||
                                    (state_q == ST_STOP && bit_end));
  assign done_idle = (state_q == ST_STOP) && bit_end && !data_avail;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
    end else if (take || state_q == ST_IDLE) begin
      tick_cnt_q <= '0;
    end else if (baud_tick) begin
      tick_cnt_q <= bit_end ? '0 : tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_idx_q <= '0;
      txd       <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (data_avail) begin
            state_q <= ST_START;
            shift_q <= data_in;
            txd     <= 1'b0;
          end
        end
        ST_START: begin
          if (bit_end) begin
            state_q   <= ST_DATA;
            txd       <= shift_q[0];
            shift_q   <= shift_q >> 1;
            bit_idx_q <= '0;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            if (bit_idx_q == IDX_LAST) begin
              state_q <= ST_STOP;
              txd     <= 1'b1;
            end else begin
              txd       <= shift_q[0];
              shift_q   <= shift_q >> 1;
              bit_idx_q <= bit_idx_q + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            if (data_avail) begin
              state_q <= ST_START;
              shift_q <= data_in;
              txd     <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_idle_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> txd);

  p_start_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(txd));

endmodule

// File: rtl/uart_txe.sv
module uart_txe
  import txe_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              txd,
  output logic              tx_end_irq
);

  logic              take, done_idle, busy, data_avail;
  logic              done_q, ie_q;
  logic [DATA_W-1:0] hold_q;

  txe_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .take       (take),
    .done_idle  (done_idle),
    .data_avail (data_avail),
    .hold_q     (hold_q),
    .done_q     (done_q),
    .ie_q       (ie_q)
  );

  txe_engine #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .data_avail (data_avail),
    .data_in    (hold_q),
    .take       (take),
    .done_idle  (done_idle),
    .busy       (busy),
    .txd        (txd)
  );

  assign tx_end_irq = done_q && ie_q;

  p_no_done_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

  p_restart_keeps_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && take) |=> !done_q && busy);

endmodule

// File: tb/sim_uart_txe.sv
module sim_uart_txe;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int TPB        = 2;
  localparam int BAUD_DIV   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              baud_tick = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              txd;
  logic              tx_end_irq;

  int checks = 0;
  int fails  = 0;
  int baud_cnt = 0;

  logic [DATA_W-1:0] exp_q[$];

  bit                mon_active = 1'b0;
  bit                mon_pending = 1'b0;
  int                mon_cnt = 0;
  int                mon_bit = 0;
  logic [DATA_W-1:0] mon_byte = '0;
  int                b2b_count = 0;
  int                irq_rises = 0;
  logic              irq_prev = 1'b0;

  uart_txe #(.DATA_W(DATA_W), .TICKS_PER_BIT(TPB)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .txd        (txd),
    .tx_end_irq (tx_end_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    baud_cnt  <= (baud_cnt == BAUD_DIV-1) ? 0 : baud_cnt + 1;
    baud_tick <= (baud_cnt == BAUD_DIV-1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Driver: queue a byte through the read-then-clear handshake.
  task automatic send_byte(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] s;
    reg_write(2'd0, b);
    reg_read(2'd1, s);
    check(s[0] == 1'b1, "R5 empty before send", int'(s[0]), 1);
    exp_q.push_back(b);
    reg_write(2'd1, '0);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !mon_active && !mon_pending) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: decode frames from the line and compare with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_prev == 1'b0 && tx_end_irq == 1'b1) irq_rises++;
      irq_prev = tx_end_irq;
      if (mon_pending) begin
        mon_pending = 1'b0;
        mon_bit++;
        if (mon_bit <= DATA_W) begin
          mon_byte[mon_bit-1] = txd;
        end else if (mon_bit == DATA_W + 1) begin
          check(txd == 1'b1, "R2 stop bit", int'(txd), 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected frame", int'(mon_byte), 0);
          end else begin
            logic [DATA_W-1:0] e;
            e = exp_q.pop_front();
            check(mon_byte == e, "R2 frame data", int'(mon_byte), int'(e));
          end
        end else begin
          if (txd == 1'b0) begin
            b2b_count++;
            mon_bit = 0;
            mon_cnt = 0;
          end else begin
            mon_active = 1'b0;
          end
        end
      end else if (!mon_active && txd == 1'b0) begin
        mon_active = 1'b1;
        mon_bit = 0;
        mon_cnt = 0;
      end
      if (mon_active && baud_tick) begin
        mon_cnt++;
        if (mon_cnt == TPB) begin
          mon_pending = 1'b1;
          mon_cnt = 0;
        end
      end
    end
  end

  task automatic run_main();
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] pats[4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 line idle", int'(txd), 1);
    check(tx_end_irq == 1'b0, "R1 irq low", int'(tx_end_irq), 0);

    // Zero written without a prior read must be ignored.
    reg_write(2'd1, '0);
    repeat (20) @(negedge clk);
    check(txd == 1'b1, "R4 unarmed write starts nothing", int'(txd), 1);
    reg_read(2'd1, r);
    check(r == 8'h03, "R1 R4 status after reset", int'(r), 3);
    reg_read(2'd2, r);
    check(r == 8'h00, "R1 control after reset", int'(r), 0);

    reg_write(2'd0, 8'h3C);
    reg_read(2'd0, r);
    check(r == 8'h3C, "R3 data readback", int'(r), 'h3C);
    reg_read(2'd1, r);
    check(r == 8'h03, "R11 flags after data write", int'(r), 3);
    check(txd == 1'b1, "R11 line after data write", int'(txd), 1);

    reg_write(2'd2, 8'h01);
    #1 check(tx_end_irq == 1'b1, "R8 irq with enable", int'(tx_end_irq), 1);
    reg_write(2'd2, 8'h00);
    #1 check(tx_end_irq == 1'b0, "R8 enable cleared drops irq", int'(tx_end_irq), 0);
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, r);
    check(r == 8'h01, "R3 control unused bits read 0", int'(r), 1);

    send_byte(8'hA5);
    repeat (2) @(negedge clk);
    check(tx_end_irq == 1'b0, "R9 handshake clears irq", int'(tx_end_irq), 0);
    reg_read(2'd1, r);
    check(r == 8'h01, "R5 R10 status after load", int'(r), 1);
    irq_rises = 0;
    send_byte(8'h5A);
    reg_read(2'd1, r);
    check(r == 8'h00, "R5 byte waiting", int'(r), 0);
    wait_drain();
    check(b2b_count == 1, "R7 gap-free restart", b2b_count, 1);
    check(irq_rises == 1, "R7 single done event", irq_rises, 1);
    reg_read(2'd1, r);
    check(r == 8'h03, "R6 flags after drain", int'(r), 3);
    check(tx_end_irq == 1'b1, "R8 irq after drain", int'(tx_end_irq), 1);

    // Status has now been read: clear done alone, keep empty.
    reg_write(2'd1, 8'h01);
    @(negedge clk);
    check(tx_end_irq == 1'b0, "R4 armed clear of done", int'(tx_end_irq), 0);
    reg_read(2'd1, r);
    check(r == 8'h01, "R4 only done cleared", int'(r), 1);
    repeat (10) @(negedge clk);
    check(txd == 1'b1, "R4 write of 1 to empty starts nothing", int'(txd), 1);

    foreach (pats[i]) begin
      send_byte(pats[i]);
      wait_drain();
      check(txd == 1'b1, "R6 line idle after frame", int'(txd), 1);
    end
    // Done was set by the last frame and not read since: unarmed clear ignored.
    reg_write(2'd1, 8'h01);
    @(negedge clk);
    check(tx_end_irq == 1'b1, "R4 unarmed clear ignored", int'(tx_end_irq), 1);
    reg_write(2'd2, 8'h00);
    #1 check(tx_end_irq == 1'b0, "R8 disable removes request", int'(tx_end_irq), 0);
    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R2: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule